// File: doc/BRIEF.md
# Cube-connected-cycles spare-row reconfiguration engine

This block decides, for a fault-tolerant cube-connected-cycles array, what each processing node must do once a set of nodes has failed. The array has 2^D cycles. Each cycle holds D working nodes at positions 0 to D-1 and one spare at position D. A failed node is repaired as a pair: the failed node and its lateral partner leave service together. The cycles above that pair then shift up by one position. Each shifted node takes over the role of the node below it through an extra substitution link. A spare enters service at the top of every shifted cycle.

The engine holds a fault bitmap. When it is idle and sees a bitmap different from the last one it accepted, it takes the new one and resolves one row per clock. It starts at position 0 and moves upward. After the working rows it resolves the spare row, and a last cycle forces every failed node to bypass. It then commits the full state array, a count of the nodes that differ from the fault-free configuration, and a flag for fault patterns that cannot be repaired. A one-cycle done pulse marks the end of the pass.

Top module: `cccr_reconfig_engine`

## Requirements
- R1: After reset, every working node reads Regular (2'b00) and every spare reads Standby (2'b11). `changed_count`, `busy`, `done` and `untolerated` are all 0.
- R2: Node (c, p), with cycle c in 0..2^D-1 and position p in 0..D, uses bit index k = p*2^D + c. The same index selects `fault_map[k]` and `node_state[2k+1:2k]`. Substitute is 2'b01 and Bypassed is 2'b10.
- R3: For a single failure at (c, i) with i < D, node (c, i) and its lateral partner (c XOR 2^i, i) both read Bypassed. This holds whether or not the partner itself has failed.
- R4: Rows are resolved in order from position 0 upward. A healthy node at position p ≥ 1 becomes Substitute when the node directly below it has failed or has already resolved to Bypassed or Substitute. Then, for p < D, any node whose partner (c XOR 2^p, p) has failed or has just become Substitute is set to Bypassed. For the spare row only the first step applies, and a spare that is not brought in stays Standby.
- R5: `changed_count` is the number of nodes whose committed state differs from the R1 state. For one failure at position i < D this is 3·2^(D-i) - 2.
- R6: Every failed node reads Bypassed in the committed result. This includes a failed spare in a cycle that has not shifted.
- R7: If a failed node would have become Substitute under R4, `untolerated` is 1 after the pass. `node_state` and `changed_count` then keep their previous values. A tolerated pass clears the flag.
- R8: A bitmap is taken only while the engine is idle and differs from the last accepted one. `busy` is then high for exactly D+2 cycles. `done` pulses for one cycle as `busy` falls, and the results update on that same edge.
- R9: Changes to `fault_map` while busy do not affect the running pass. A bitmap that still differs at the end of the pass starts a new pass from position 0.
- R10: Returning the bitmap to all zeros restores the R1 node states with `changed_count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_map | input | (D+1)·2^D | Failed-node bitmap, bit p*2^D + c for node (c, p) |
| node_state | output | 2·(D+1)·2^D | Committed per-node state, two bits per node |
| changed_count | output | clog2((D+1)·2^D+1) | Nodes differing from the fault-free state |
| busy | output | 1 | A resolution pass is running |
| done | output | 1 | One-cycle pulse when a pass commits |
| untolerated | output | 1 | The last pass met an unrepairable fault |

## Verification
A single failure is placed in each working row so the doubling of substituted and bypassed nodes is checked against the closed-form count. This shows whether the row order and the lateral rule are both correct. A lone failed spare separates the final forcing step from the row rules. Adding a failure directly above an earlier one must raise the flag and leave the previous result in place. A bitmap changed mid-pass checks that the first pass finishes unaffected and that the second pass is picked up afterwards. Seeded random maps with up to three failures cover interacting pairs that the directed cases do not.

// File: rtl/cccr_pkg.sv
package cccr_pkg;
   typedef enum logic [1:0] {
      NS_REG  = 2'b00,
      NS_SUB  = 2'b01,
      NS_BYP  = 2'b10,
      NS_STBY = 2'b11
   } node_st_e;
endpackage

// File: rtl/cccr_row.sv
module cccr_row
   import cccr_pkg::*;
#(
   parameter int D  = 3,
   parameter int NC = 1 << D,
   parameter int RW = $clog2(D + 1)
) (
   input  logic [RW-1:0]          pos,
   input  logic                   has_below,
   input  logic                   is_spare,
   input  logic [NC-1:0]          flt,
   input  logic [NC-1:0]          below_flt,
   input  logic [NC-1:0][1:0]     below_st,
   output logic [NC-1:0][1:0]     row_st,
   output logic                   row_untol
);
   localparam int CW = D;

   logic [NC-1:0]      shifted;
   logic [NC-1:0][1:0] first;

   // backward-neighbour step, one instance per cycle
   for (genvar c = 0; c < NC; c++) begin : g_first
      assign shifted[c] = has_below && (below_flt[c] || (below_st[c] != NS_REG));
      assign first[c]   = shifted[c] ? NS_SUB : (is_spare ? NS_STBY : NS_REG);
   end

   assign row_untol = |(flt & shifted);

   // lateral step: partner differs in address bit 'pos'
   for (genvar c = 0; c < NC; c++) begin : g_lat
      logic [CW-1:0] pidx;
      assign pidx = CW'(c) ^ (CW'(1) << pos);
      always_comb begin
         if (!is_spare && (flt[pidx] || (first[pidx] == NS_SUB)))
            row_st[c] = NS_BYP;
         else
            row_st[c] = first[c];
      end
   end
endmodule

// File: rtl/cccr_popcnt.sv
module cccr_popcnt #(
   parameter int N    = 32,
   parameter int CNTW = $clog2(N + 1)
) (
   input  logic [N-1:0]    bits,
   output logic [CNTW-1:0] count
);
   always_comb begin
      count = '0;
      for (int k = 0; k < N; k++)
         count = count + CNTW'(bits[k]);
   end
endmodule

// File: rtl/cccr_reconfig_engine.sv
module cccr_reconfig_engine
   import cccr_pkg::*;
#(
   parameter int D = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [(D+1)*(1<<D)-1:0]                fault_map,
   output logic [2*(D+1)*(1<<D)-1:0]              node_state,
   output logic [$clog2((D+1)*(1<<D)+1)-1:0]      changed_count,
   output logic                                   busy,
   output logic                                   done,
   output logic                                   untolerated
);
   localparam int NC   = 1 << D;
   localparam int ROWS = D + 1;
   localparam int N    = NC * ROWS;
   localparam int CNTW = $clog2(N + 1);
   localparam int RW   = $clog2(D + 1);
   localparam int PHW  = $clog2(D + 2);

   if (D < 1 || D > 4) begin : g_bad_dim
      $error("cccr_reconfig_engine: D must lie in 1..4");
   end

   logic [N-1:0]                map_q;
   logic [ROWS-1:0][NC-1:0][1:0] work_q, base_arr;
   logic [PHW-1:0]              phase_q;
   logic                        busy_q, done_q, untol_q, untol_acc;
   logic [N-1:0][1:0]           state_q, fin;
   logic [N-1:0]                diff;
   logic [CNTW-1:0]             cnt_q, fin_cnt;

   logic [RW-1:0]               rsel;
   logic [NC-1:0]               cur_flt, below_flt;
   logic [NC-1:0][1:0]          below_st, row_st;
   logic                        row_untol;

   // fault-free reference configuration
   always_comb begin
      for (int p = 0; p < ROWS; p++)
         for (int c = 0; c < NC; c++)
            base_arr[p][c] = (p == D) ? NS_STBY : NS_REG;
   end

   assign rsel = (phase_q > PHW'(D)) ? RW'(D) : phase_q[RW-1:0];

   always_comb begin
      int bidx;
      bidx = (rsel == '0) ? 0 : int'(rsel) - 1;
      for (int c = 0; c < NC; c++) begin
         cur_flt[c]   = map_q[int'(rsel) * NC + c];
         below_flt[c] = (rsel == '0) ? 1'b0 : map_q[bidx * NC + c];
         below_st[c]  = (rsel == '0) ? NS_REG : work_q[bidx][c];
      end
   end

   cccr_row #(.D(D), .NC(NC), .RW(RW)) u_row (
      .pos       (rsel),
      .has_below (rsel != '0),
      .is_spare  (rsel == RW'(D)),
      .flt       (cur_flt),
      .below_flt (below_flt),
      .below_st  (below_st),
      .row_st    (row_st),
      .row_untol (row_untol)
   );

   // final forcing of failed nodes and difference against the reference
   always_comb begin
      for (int p = 0; p < ROWS; p++)
         for (int c = 0; c < NC; c++) begin
            fin[p*NC + c]  = map_q[p*NC + c] ? NS_BYP : work_q[p][c];
            diff[p*NC + c] = (fin[p*NC + c] != base_arr[p][c]);
         end
   end

   cccr_popcnt #(.N(N), .CNTW(CNTW)) u_cnt (
      .bits  (diff),
      .count (fin_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q     <= '0;
         work_q    <= base_arr;
         phase_q   <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         untol_q   <= 1'b0;
         untol_acc <= 1'b0;
         cnt_q     <= '0;
         for (int p = 0; p < ROWS; p++)
            for (int c = 0; c < NC; c++)
               state_q[p*NC + c] <= (p == D) ? NS_STBY : NS_REG;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (fault_map != map_q) begin
               map_q     <= fault_map;
               busy_q    <= 1'b1;
               phase_q   <= '0;
               untol_acc <= 1'b0;
               work_q    <= base_arr;
            end
         end else if (phase_q <= PHW'(D)) begin
            work_q[rsel] <= row_st;
            untol_acc    <= untol_acc | row_untol;
            phase_q      <= phase_q + 1'b1;
         end else begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            untol_q <= untol_acc;
            if (!untol_acc) begin
               state_q <= fin;
               cnt_q   <= fin_cnt;
            end
         end
      end
   end

   assign node_state    = state_q;
   assign changed_count = cnt_q;
   assign busy          = busy_q;
   assign done          = done_q;
   assign untolerated   = untol_q;
endmodule

// File: rtl/cccr_reconfig_checker.sv
module cccr_reconfig_checker #(
   parameter int D = 3
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [2*(D+1)*(1<<D)-1:0]          node_state,
   input logic [$clog2((D+1)*(1<<D)+1)-1:0]  changed_count,
   input logic                               busy,
   input logic                               done,
   input logic                               untolerated
);
   localparam int N = (D + 1) * (1 << D);

   int busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   assert_pass_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == D + 2));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(node_state) && $stable(changed_count)));

   assert_untol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && untolerated) |-> ($stable(node_state) && $stable(changed_count)));

   assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(changed_count) <= N);
endmodule

bind cccr_reconfig_engine cccr_reconfig_checker #(.D(D)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .node_state    (node_state),
   .changed_count (changed_count),
   .busy          (busy),
   .done          (done),
   .untolerated   (untolerated)
);

// File: tb/tb_cccr_reconfig_engine.sv
module tb_cccr_reconfig_engine;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int D          = 3;
   localparam int NC         = 1 << D;
   localparam int N          = NC * (D + 1);
   localparam int CNTW       = $clog2(N + 1);
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      fault_map = '0;
   logic [2*N-1:0]    node_state;
   logic [CNTW-1:0]   changed_count;
   logic              busy, done, untolerated;

   int vectors = 0, miscompares = 0;
   logic [N-1:0]   acc_map = '0;
   logic [2*N-1:0] exp_st;
   int             exp_cnt = 0;
   bit             exp_ut = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cccr_reconfig_engine #(.D(D)) dut (
      .clk(clk), .rst_n(rst_n), .fault_map(fault_map), .node_state(node_state),
      .changed_count(changed_count), .busy(busy), .done(done), .untolerated(untolerated)
   );

   function automatic logic [1:0] basev(int p);
      return (p == D) ? 2'b11 : 2'b00;
   endfunction

   function automatic logic [1:0] st_at(int c, int p);
      return node_state[2*(p*NC + c) +: 2];
   endfunction

   task automatic model(input logic [N-1:0] m, output logic [2*N-1:0] st,
                        output int cnt, output bit ut);
      logic [1:0] a [D+1][NC];
      logic [1:0] s1 [NC];
      ut = 0;
      for (int p = 0; p <= D; p++) begin
         for (int c = 0; c < NC; c++) begin
            bit sh;
            sh = 0;
            if (p > 0) sh = m[(p-1)*NC + c] || (a[p-1][c] != 2'b00);
            s1[c] = sh ? 2'b01 : basev(p);
            if (m[p*NC + c] && sh) ut = 1;
         end
         for (int c = 0; c < NC; c++) begin
            int q;
            q = c ^ (1 << p);
            if (p < D && (m[p*NC + q] || s1[q] == 2'b01)) a[p][c] = 2'b10;
            else a[p][c] = s1[c];
         end
      end
      cnt = 0;
      for (int p = 0; p <= D; p++)
         for (int c = 0; c < NC; c++) begin
            logic [1:0] v;
            v = m[p*NC + c] ? 2'b10 : a[p][c];
            st[2*(p*NC + c) +: 2] = v;
            if (v != basev(p)) cnt++;
         end
   endtask

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(node_state == exp_st, {req, " node_state"}, 128'(node_state), 128'(exp_st));
      chk(int'(changed_count) == exp_cnt, {req, " changed_count"}, 128'(changed_count), 128'(exp_cnt));
      chk(untolerated == exp_ut, {req, " untolerated"}, 128'(untolerated), 128'(exp_ut));
   endtask

   task automatic wait_done(output int busy_cycles);
      int t;
      busy_cycles = 0;
      t = 0;
      while (!done && t < 60) begin
         @(negedge clk);
         if (busy) busy_cycles++;
         t++;
      end
      if (!done) begin
         miscompares++;
         $display("FAIL R8 timeout actual=%0d expected=done", t);
      end
   endtask

   task automatic absorb(input logic [N-1:0] m);
      logic [2*N-1:0] st;
      int cnt;
      bit ut;
      model(m, st, cnt, ut);
      exp_ut = ut;
      if (!ut) begin
         exp_st  = st;
         exp_cnt = cnt;
      end
   endtask

   task automatic apply(input logic [N-1:0] m, input string req);
      int bc;
      @(negedge clk);
      fault_map = m;
      if (m != acc_map) begin
         wait_done(bc);
         chk(bc == D + 2, "R8 busy length", 128'(bc), 128'(D + 2));
         acc_map = m;
         absorb(m);
      end else begin
         repeat (3) @(negedge clk);
      end
      check_all(req);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int p = 0; p <= D; p++)
         for (int c = 0; c < NC; c++)
            exp_st[2*(p*NC + c) +: 2] = basev(p);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all("R1 reset");
      chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", 128'({busy, done}), 128'(0));

      // single failure in each working row: R2, R3, R4, R5
      for (int i = 0; i < D; i++) begin
         int c;
         logic [N-1:0] m;
         c = (i * 3 + 1) % NC;
         m = '0;
         m[i*NC + c] = 1'b1;
         apply(m, "R4 single fault");
         chk(st_at(c, i) == 2'b10, "R3 failed node bypassed", 128'(st_at(c, i)), 128'(2));
         chk(st_at(c ^ (1 << i), i) == 2'b10, "R3 partner bypassed (R2 index)",
             128'(st_at(c ^ (1 << i), i)), 128'(2));
         chk(st_at(c, D) == 2'b01, "R4 spare brought in", 128'(st_at(c, D)), 128'(1));
         if (i < D - 1)
            chk(st_at(c, i + 1) == 2'b01, "R4 successor substitute",
                128'(st_at(c, i + 1)), 128'(1));
         chk(int'(changed_count) == 3 * (1 << (D - i)) - 2, "R5 closed-form count",
             128'(changed_count), 128'(3 * (1 << (D - i)) - 2));
      end

      // R6 lone failed spare in an unshifted cycle
      begin
         logic [N-1:0] m;
         m = '0;
         m[D*NC + 5] = 1'b1;
         apply(m, "R6 failed spare");
         chk(st_at(5, D) == 2'b10, "R6 spare forced bypassed", 128'(st_at(5, D)), 128'(2));
         chk(changed_count == CNTW'(1), "R6 count", 128'(changed_count), 128'(1));
      end

      // R7 failure directly above an earlier one
      begin
         logic [N-1:0] m;
         logic [2*N-1:0] prev;
         m = '0;
         m[0*NC + 2] = 1'b1;
         apply(m, "R7 setup");
         prev = node_state;
         m[1*NC + 2] = 1'b1;
         apply(m, "R7 untolerated");
         chk(untolerated == 1'b1, "R7 flag", 128'(untolerated), 128'(1));
         chk(node_state == prev, "R7 state held", 128'(node_state), 128'(prev));
      end

      // R9 change while busy
      begin
         logic [N-1:0] ma, mb;
         int bc;
         ma = '0; ma[1*NC + 3] = 1'b1;
         mb = '0; mb[0*NC + 6] = 1'b1;
         @(negedge clk);
         fault_map = ma;
         @(negedge clk);
         chk(busy == 1'b1, "R9 pass started", 128'(busy), 128'(1));
         fault_map = mb;
         wait_done(bc);
         acc_map = ma;
         absorb(ma);
         check_all("R9 first pass unaffected");
         @(negedge clk);
         wait_done(bc);
         acc_map = mb;
         absorb(mb);
         check_all("R9 pending map picked up");
      end

      // seeded random maps with up to three failures (R4, R5, R7)
      for (int r = 0; r < 40; r++) begin
         logic [N-1:0] m;
         int k;
         m = '0;
         k = $urandom_range(0, 3);
         for (int j = 0; j < k; j++) m[$urandom_range(0, N - 1)] = 1'b1;
         apply(m, "R4 random");
      end

      // R10 back to fault-free
      apply('0, "R10 cleared");
      chk(changed_count == '0, "R10 count zero", 128'(changed_count), 128'(0));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule